// File: doc/BRIEF.md
# Game Move Timing Sequencer

This block paces a falling-block puzzle game. A free-running divider marks out one move period at a time. The period length depends on the selected drop rate: slow, medium or fast. At the start of each period the block walks through seven phases. Each phase raises one single-cycle strobe, and the strobes step a piece-control state machine and a playfield-update state machine through their work for that move.

Player requests (left, right, rotate, drop) arrive as one-cycle pulses at any moment. The block keeps each request in a sticky latch until the clear phase of the move. However many pulses arrive during one move, the request counts once.

The drop rate normally comes from a pair of switches. A select input can instead let an audio event override the switches. While the audio mode is selected and the event input is high, the rate is fast.

Top module: `move_sequencer`

## Requirements
- R1: The effective pace sets the move period P in clock cycles: pace 2'b00 is slow (P = CLK_HZ/RATE_SLOW), 2'b01 is medium (P = CLK_HZ/RATE_MED), and 2'b10 or 2'b11 is fast (P = CLK_HZ/RATE_FAST).
- R2: Counting rising edges from the first edge at which reset is released as edge 1, the clean strobe is first visible after edge P and then after every further P edges.
- R3: Each move issues its strobes in the order clean, coord, collide, droprow, game, swap, clear. Strobe k (clean being 0) is visible after edge m·P + k·GAP_CYCLES for move m, where GAP_CYCLES is at least 4.
- R4: At most one strobe is high in any cycle, and each strobe lasts exactly one cycle.
- R5: Request bit i (bit 0 left, bit 1 right, bit 2 rotate, bit 3 drop) goes high in the cycle after its pulse input is sampled high. It stays high until the clear strobe, and repeated pulses leave it at one.
- R6: In the cycle after a clear strobe, the request vector equals the pulse inputs sampled together with that strobe. A pulse that coincides with the clear is therefore kept for the next move, and all other held requests are dropped.
- R7: With use_audio high, the audio event input high forces the fast period whatever the switches say. With audio_hit low, the switch pace applies.
- R8: With use_audio low, audio_hit has no effect on the period.
- R9: While rst_n is low, every strobe and every request bit is low. Reset restarts the divider and the phase sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pace_sw | input | 2 | Switch-selected pace (00 slow, 01 medium, 1x fast) |
| use_audio | input | 1 | 1: audio event may override the switches |
| audio_hit | input | 1 | Low-band audio magnitude above threshold |
| btn_pulse | input | 4 | Request pulses: [0] left, [1] right, [2] rotate, [3] drop |
| req_held | output | 4 | Sticky requests, same bit order |
| stb_clean | output | 1 | Phase 0: erase the piece from the playfield |
| stb_coord | output | 1 | Phase 1: compute the tentative coordinates |
| stb_collide | output | 1 | Phase 2: test for collision |
| stb_droprow | output | 1 | Phase 3: drop one row or spawn a piece |
| stb_game | output | 1 | Phase 4: write the playfield |
| stb_swap | output | 1 | Phase 5: commit the coordinates |
| stb_clear | output | 1 | Phase 6: release the request latches |

## Verification
The strobe train is run under every pace code, including both fast encodings, and the exact edge of each strobe is predicted. An off-by-one in the divider or in the gap count shows up as a timing mismatch, and a mix-up of pace codes shows up as a wrong period. The audio override is tried in three ways: selected with the event high, deselected with the event high, and selected with the event low under the medium switch setting. These three runs separate a correct override from one that ignores the select and from one that ignores the event. The request latches get repeated pulses, then a pulse that lands on the clear strobe, then a quiet move. This pattern separates correct capture from pulse counting, from a clear that wins over a coincident pulse, and from a latch that never releases.

// File: rtl/move_seq_pkg.sv
// Package: shared types and helpers for the move sequencer.
// Assumes the phase order below is the order in which the strobes fire.
package move_seq_pkg;

    localparam int NUM_STROBES = 7;
    localparam int NUM_BUTTONS = 4;

    typedef enum logic [1:0] {
        PACE_SLOW = 2'b00,
        PACE_MED  = 2'b01,
        PACE_FAST = 2'b10
    } pace_e;

    typedef enum logic [2:0] {
        PH_CLEAN   = 3'd0,
        PH_COORD   = 3'd1,
        PH_COLLIDE = 3'd2,
        PH_DROPROW = 3'd3,
        PH_GAME    = 3'd4,
        PH_SWAP    = 3'd5,
        PH_CLEAR   = 3'd6
    } phase_e;

    // Index of the highest set bit of a strobe vector (0 when the vector is empty)
    function automatic logic [2:0] strobe_index(input logic [NUM_STROBES-1:0] v);
        logic [2:0] idx;
        idx = 3'd0;
        for (int i = 0; i < NUM_STROBES; i++) begin
            if (v[i]) idx = 3'(i);
        end
        return idx;
    endfunction

endpackage

// File: rtl/pace_divider.sv
// Module: pace_divider
// Chooses the effective pace from the switches and the audio override.
// Counts out one move period and emits a one-cycle move_tick at its end.
// Assumes CLK_HZ is an integer multiple of each rate and that RATE_SLOW
// is the smallest rate, so that it sets the counter width.
module pace_divider
    import move_seq_pkg::*;
#(
    parameter int unsigned CLK_HZ    = 50_000_000,
    parameter int unsigned RATE_SLOW = 1,
    parameter int unsigned RATE_MED  = 2,
    parameter int unsigned RATE_FAST = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] pace_sw,
    input  logic       use_audio,
    input  logic       audio_hit,
    output logic       move_tick
);

    localparam int unsigned PER_SLOW = CLK_HZ / RATE_SLOW;
    localparam int unsigned PER_MED  = CLK_HZ / RATE_MED;
    localparam int unsigned PER_FAST = CLK_HZ / RATE_FAST;
    localparam int          CW       = $clog2(PER_SLOW + 1);
    localparam logic [CW-1:0] LIM_SLOW = CW'(PER_SLOW - 1);
    localparam logic [CW-1:0] LIM_MED  = CW'(PER_MED - 1);
    localparam logic [CW-1:0] LIM_FAST = CW'(PER_FAST - 1);

    pace_e         eff_pace;
    logic [CW-1:0] limit;
    logic [CW-1:0] cnt_q;

    // Effective pace: the audio event wins only when audio mode is selected
    always_comb begin
        if (use_audio && audio_hit) begin
            eff_pace = PACE_FAST;
        end else if (pace_sw[1]) begin
            eff_pace = PACE_FAST;
        end else if (pace_sw[0]) begin
            eff_pace = PACE_MED;
        end else begin
            eff_pace = PACE_SLOW;
        end
    end

    // Terminal count for the selected pace
    always_comb begin
        case (eff_pace)
            PACE_FAST: limit = LIM_FAST;
            PACE_MED:  limit = LIM_MED;
            default:   limit = LIM_SLOW;
        endcase
    end

    // A shortened period wraps at once, never overruns
    assign move_tick = (cnt_q >= limit);

    // Period counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (move_tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R1: the counter never passes the slow terminal count
    a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIM_SLOW);

endmodule

// File: rtl/strobe_sequencer.sv
// Module: strobe_sequencer
// Starts a new seven-phase train on each move_tick. Each phase raises its
// strobe for one cycle, then waits GAP cycles before the next phase.
// Assumes GAP >= 4. A tick that comes mid-train restarts it at phase 0.
module strobe_sequencer
    import move_seq_pkg::*;
#(
    parameter int GAP = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   move_tick,
    output logic [NUM_STROBES-1:0] strobe
);

    localparam int GW = $clog2(GAP);
    localparam logic [GW-1:0] GAP_LAST = GW'(GAP - 1);
    localparam logic [2:0]    PH_LAST  = 3'(NUM_STROBES - 1);

    logic          active_q;
    logic [2:0]    phase_q;
    logic [GW-1:0] gap_q;

    // Phase and gap counters; the train stops after the last phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            phase_q  <= '0;
            gap_q    <= '0;
        end else if (move_tick) begin
            active_q <= 1'b1;
            phase_q  <= '0;
            gap_q    <= '0;
        end else if (active_q) begin
            if (gap_q == GAP_LAST) begin
                gap_q <= '0;
                if (phase_q == PH_LAST) begin
                    active_q <= 1'b0;
                end else begin
                    phase_q <= phase_q + 1'b1;
                end
            end else begin
                gap_q <= gap_q + 1'b1;
            end
        end
    end

    // Strobe decode: one bit in the first cycle of each phase, none in reset
    always_comb begin
        strobe = '0;
        if (rst_n && active_q && gap_q == '0) begin
            strobe = {{(NUM_STROBES-1){1'b0}}, 1'b1} << phase_q;
        end
    end

    // R4: never two strobes at once
    a_r4_one_hot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strobe));

    // R4: a strobe lasts a single cycle
    a_r4_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe != '0) |=> (strobe == '0));

endmodule

// File: rtl/sticky_latches.sv
// Module: sticky_latches
// Holds each request pulse until the clear strobe. A pulse that lands on
// the clear cycle is carried into the next move.
// Assumes the pulses are already synchronous to clk.
module sticky_latches
    import move_seq_pkg::*;
#(
    parameter int N = NUM_BUTTONS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic [N-1:0] pulse,
    output logic [N-1:0] held
);

    // Capture-or-release of every request bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= '0;
        end else if (clear) begin
            held <= pulse;
        end else begin
            held <= held | pulse;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_chk
        // R5: a sampled pulse is held on the next cycle
        a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
            pulse[i] |=> held[i]);
        // R5: a held request survives until the clear strobe
        a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (held[i] && !clear) |=> held[i]);
    end

    // R6: after clear, only the coincident pulses remain
    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (held == $past(pulse)));

endmodule

// File: rtl/move_sequencer.sv
// Module: move_sequencer (top)
// Per-move heartbeat: pace-selected divider, seven-phase strobe train and
// sticky request latches. Assumes synchronous inputs, an active-low
// synchronous reset, and 7*GAP_CYCLES no longer than the fast period.
module move_sequencer
    import move_seq_pkg::*;
#(
    parameter int unsigned CLK_HZ     = 50_000_000,
    parameter int unsigned RATE_SLOW  = 1,
    parameter int unsigned RATE_MED   = 2,
    parameter int unsigned RATE_FAST  = 5,
    parameter int          GAP_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] pace_sw,
    input  logic       use_audio,
    input  logic       audio_hit,
    input  logic [3:0] btn_pulse,
    output logic [3:0] req_held,
    output logic       stb_clean,
    output logic       stb_coord,
    output logic       stb_collide,
    output logic       stb_droprow,
    output logic       stb_game,
    output logic       stb_swap,
    output logic       stb_clear
);

    logic                   move_tick;
    logic [NUM_STROBES-1:0] strobe;

    pace_divider #(
        .CLK_HZ   (CLK_HZ),
        .RATE_SLOW(RATE_SLOW),
        .RATE_MED (RATE_MED),
        .RATE_FAST(RATE_FAST)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .pace_sw  (pace_sw),
        .use_audio(use_audio),
        .audio_hit(audio_hit),
        .move_tick(move_tick)
    );

    strobe_sequencer #(
        .GAP(GAP_CYCLES)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .move_tick(move_tick),
        .strobe   (strobe)
    );

    sticky_latches #(
        .N(NUM_BUTTONS)
    ) u_latch (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(strobe[PH_CLEAR]),
        .pulse(btn_pulse),
        .held (req_held)
    );

    assign stb_clean   = strobe[PH_CLEAN];
    assign stb_coord   = strobe[PH_COORD];
    assign stb_collide = strobe[PH_COLLIDE];
    assign stb_droprow = strobe[PH_DROPROW];
    assign stb_game    = strobe[PH_GAME];
    assign stb_swap    = strobe[PH_SWAP];
    assign stb_clear   = strobe[PH_CLEAR];

    // Order tracking for the checks below: index of the last strobe seen
    logic [2:0] last_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= 3'(NUM_STROBES - 1);
        end else if (strobe != '0) begin
            last_q <= strobe_index(strobe);
        end
    end

    for (genvar k = 1; k < NUM_STROBES; k++) begin : g_order
        // R3: every phase after the first follows its predecessor
        a_r3_order: assert property (@(posedge clk) disable iff (!rst_n)
            strobe[k] |-> (last_q == 3'(k - 1)));
    end

    // R9: reset leaves no strobe and no held request
    a_r9_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (strobe == '0 && req_held == '0));

endmodule

// File: tb/tb_move_sequencer.sv
`timescale 1ns/1ps
module tb_move_sequencer;

    localparam int unsigned CLK_HZ = 1000;
    localparam int GAP = 8;
    localparam int P_SLOW = 1000;
    localparam int P_MED  = 500;
    localparam int P_FAST = 200;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] pace_sw = 2'b00;
    logic       use_audio = 1'b0;
    logic       audio_hit = 1'b0;
    logic [3:0] btn_pulse = 4'h0;
    logic [3:0] req_held;
    logic       stb_clean, stb_coord, stb_collide, stb_droprow;
    logic       stb_game, stb_swap, stb_clear;

    always #2 clk = ~clk;

    move_sequencer #(
        .CLK_HZ(CLK_HZ), .RATE_SLOW(1), .RATE_MED(2), .RATE_FAST(5), .GAP_CYCLES(GAP)
    ) dut (
        .clk(clk), .rst_n(rst_n), .pace_sw(pace_sw), .use_audio(use_audio),
        .audio_hit(audio_hit), .btn_pulse(btn_pulse), .req_held(req_held),
        .stb_clean(stb_clean), .stb_coord(stb_coord), .stb_collide(stb_collide),
        .stb_droprow(stb_droprow), .stb_game(stb_game), .stb_swap(stb_swap),
        .stb_clear(stb_clear)
    );

    typedef struct { int edge_n; int idx; } exp_t;
    exp_t  q[$];
    int    checks = 0;
    int    fails  = 0;
    int    ecount = 0;
    string cur_tag = "R9";
    bit    done = 1'b0;

    logic [6:0] stb_vec;
    assign stb_vec = {stb_clear, stb_swap, stb_game, stb_droprow,
                      stb_collide, stb_coord, stb_clean};

    // edges counted since reset release
    always @(posedge clk) begin
        if (!rst_n) ecount <= 0;
        else        ecount <= ecount + 1;
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // driver: push the predicted strobes of n moves with period p
    task automatic push_moves(input int p, input int n);
        for (int m = 1; m <= n; m++) begin
            for (int k = 0; k < 7; k++) begin
                exp_t e;
                e.edge_n = m * p + k * GAP;
                e.idx    = k;
                q.push_back(e);
            end
        end
    endtask

    // monitor: compare each observed strobe with the queue head
    always @(negedge clk) begin
        if (rst_n && stb_vec != 7'd0) begin
            int idx;
            idx = 0;
            for (int i = 0; i < 7; i++) if (stb_vec[i]) idx = i;
            check($countones(stb_vec) == 1, "R4", "strobes high at once",
                  $countones(stb_vec), 1);
            if (q.size() == 0) begin
                check(1'b0, cur_tag, "unexpected strobe at edge", ecount, -1);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(e.edge_n == ecount, (idx == 0) ? "R2" : cur_tag,
                      "strobe edge", ecount, e.edge_n);
                check(e.idx == idx, "R3", "strobe index", idx, e.idx);
            end
        end
    end

    task automatic wait_edge(input int n);
        while (ecount < n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        btn_pulse = 4'hF;
        repeat (3) @(negedge clk);
        check(stb_vec == 7'd0, "R9", "strobes in reset", int'(stb_vec), 0);
        check(req_held == 4'h0, "R9", "requests in reset", int'(req_held), 0);
        btn_pulse = 4'h0;
        q.delete();
        rst_n = 1'b1;
    endtask

    task automatic end_scn(input int stop_edge);
        wait_edge(stop_edge);
        check(q.size() == 0, cur_tag, "strobes still missing", q.size(), 0);
    endtask

    task automatic pulse_btn(input logic [3:0] v);
        btn_pulse = v;
        @(negedge clk);
        btn_pulse = 4'h0;
    endtask

    initial begin
        // R1 slow pace, with the latch checks of R5 and R6 embedded
        pace_sw = 2'b00; use_audio = 1'b0; audio_hit = 1'b0;
        cur_tag = "R1";
        do_reset();
        push_moves(P_SLOW, 2);
        wait_edge(10);  pulse_btn(4'b0001);
        wait_edge(20);  pulse_btn(4'b0001);
        wait_edge(21);
        check(req_held == 4'b0001, "R5", "left held once", int'(req_held), 1);
        wait_edge(30);  pulse_btn(4'b1000);
        wait_edge(31);
        check(req_held == 4'b1001, "R5", "left and drop held", int'(req_held), 9);
        wait_edge(1048);
        check(req_held == 4'b1001, "R5", "held until clear", int'(req_held), 9);
        pulse_btn(4'b0100);
        check(req_held == 4'b0100, "R6", "pulse on clear kept", int'(req_held), 4);
        wait_edge(2049);
        check(req_held == 4'b0000, "R5", "released by clear", int'(req_held), 0);
        end_scn(2100);

        // R1 medium pace
        pace_sw = 2'b01; cur_tag = "R1";
        do_reset();
        push_moves(P_MED, 2);
        end_scn(1100);

        // R1 fast pace, both encodings
        pace_sw = 2'b10; cur_tag = "R1";
        do_reset();
        push_moves(P_FAST, 2);
        end_scn(500);
        pace_sw = 2'b11; cur_tag = "R1";
        do_reset();
        push_moves(P_FAST, 2);
        end_scn(500);

        // R7 audio event forces fast
        pace_sw = 2'b00; use_audio = 1'b1; audio_hit = 1'b1; cur_tag = "R7";
        do_reset();
        push_moves(P_FAST, 2);
        end_scn(500);

        // R8 audio event ignored when not selected
        use_audio = 1'b0; audio_hit = 1'b1; cur_tag = "R8";
        do_reset();
        push_moves(P_SLOW, 1);
        end_scn(1100);

        // R7 audio mode without event follows the switches
        pace_sw = 2'b01; use_audio = 1'b1; audio_hit = 1'b0; cur_tag = "R7";
        do_reset();
        push_moves(P_MED, 2);
        end_scn(1100);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule